// File: doc/BRIEF.md
# Host Communication Port Register Block

This block gives a host processor a small register window onto a word-level link to an attached processor module. The host posts a 32-bit word into an outgoing holding register. The link side picks the word up and later reports it as taken. Words coming the other way land in an incoming holding register, where the host reads them. Each direction has a full flag. The link side sees ready and valid style signals that follow those flags.

The block also collects interrupt causes. These are the outgoing word being taken, an incoming word arriving, a level request from a test controller, and a request from the module. Each cause is gated by its own enable, and the gated causes are combined into one level interrupt toward the host. Two of the causes are latched events that the host clears by writing ones. The module request is latched until cleared. A control register drives pull-low lines toward the module: a reset line, a group of flag lines and a non-maskable interrupt line.

Register offsets (byte addresses): 10h is the data window, 14h is control on write and status on read, and 18h is interrupt control. Reads return data on the clock after the read strobe.

Top module: `hcomm_regs`

## Requirements
- R1: Writes and reads decode byte offsets 10h, 14h and 18h. `bus_rdata` is registered and valid one clock after `bus_rd`. Any other offset reads as zero.
- R2: A write to 10h while the outgoing register is empty loads the word and sets the outgoing full flag (status bit 0). It also raises `tx_valid` with the word on `tx_data`.
- R3: A write to 10h while the outgoing full flag is set is ignored, and `tx_data` keeps the earlier word.
- R4: A `tx_take` pulse while the outgoing register is full clears the full flag and sets the latched sent event (status bit 4).
- R5: An `rx_arrive` pulse while the incoming register is empty stores `rx_data`. It sets the incoming full flag (status bit 1) and the latched arrival event (status bit 5), and drops `rx_ready`. An arrival while the register is full is ignored.
- R6: A read of 10h returns the stored incoming word and clears the incoming full flag.
- R7: Interrupt control write bits 3:0 are the enables for status bits 4, 5, 6 and 7 in that order, and they read back in bits 3:0. Writing one to bit 4 clears the sent event, and writing one to bit 5 clears the arrival event.
- R8: The module request status (bit 7) sets while `mod_irq_req` is high and stays set after the request drops. It clears only when one is written to interrupt control bit 6 while the request is low.
- R9: Status bit 6 follows the `tbc_irq` level and is not latched.
- R10: `host_irq` is the OR of status bits 7:4, each ANDed with its enable, registered one clock after the sources change. It also appears in status bit 3. A cause whose enable is clear never raises `host_irq`.
- R11: A control write sets `site_rst_pull` from bit 0, `flag_pull[2:0]` from bits 3:1 and `nmi_pull` from bit 4. A one means the line is pulled low.
- R12: Reset clears all flags, events, enables and pull outputs, except `site_rst_pull`. That output is driven high in reset and stays high until a control write clears bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one clock after the strobe |
| tx_valid | output | 1 | Outgoing word waiting |
| tx_data | output | 32 | Outgoing word |
| tx_take | input | 1 | Link has taken the outgoing word |
| rx_arrive | input | 1 | Incoming word strobe |
| rx_data | input | 32 | Incoming word |
| rx_ready | output | 1 | Incoming register empty |
| mod_irq_req | input | 1 | Module interrupt request level |
| tbc_irq | input | 1 | Test controller interrupt level |
| site_rst_pull | output | 1 | Pull module reset low |
| flag_pull | output | 3 | Pull flag lines low |
| nmi_pull | output | 1 | Pull non-maskable interrupt low |
| host_irq | output | 1 | Host interrupt level |

## Verification
Flags, events, enables and control pins change at the clock edge that samples the strobe or the link pulse. `host_irq` and status bit 3 follow one edge later, and read data is due one edge after the read strobe. The bench drives on falling edges and waits two edges after every stimulus before it samples pins or issues a status read. Read results are compared by a monitor that pops an expected value on the falling edge after the clock that accepted each read.

// File: rtl/hcomm_pkg.sv
package hcomm_pkg;
  // byte offsets of the register window
  localparam logic [7:0] OFS_DATA = 8'h10;
  localparam logic [7:0] OFS_CTRL = 8'h14;
  localparam logic [7:0] OFS_INTC = 8'h18;

  // status bit positions (bits 7:4 are the gated causes)
  localparam int ST_OBF    = 0;
  localparam int ST_IBF    = 1;
  localparam int ST_IRQ    = 3;
  localparam int ST_SENT   = 4;
  localparam int ST_ARRV   = 5;
  localparam int ST_TBC    = 6;
  localparam int ST_PROC   = 7;

  // interrupt control bit positions
  localparam int NUM_CAUSE = 4;
  localparam int IC_CLR_SENT = 4;
  localparam int IC_CLR_ARRV = 5;
  localparam int IC_CLR_PROC = 6;

  // control bit positions
  localparam int CT_RST = 0;
  localparam int CT_FLAG_LO = 1;
endpackage

// File: rtl/hcomm_txbuf.sv
module hcomm_txbuf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [DW-1:0] load_word,
  input  logic          take,
  input  logic          clr_sent,
  output logic          full,
  output logic [DW-1:0] word,
  output logic          sent_ev
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else if (full && take) begin
      full <= 1'b0;
    end else if (load && !full) begin
      full <= 1'b1;
      word <= load_word;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                sent_ev <= 1'b0;
    else if (full && take)  sent_ev <= 1'b1;
    else if (clr_sent)      sent_ev <= 1'b0;
  end

  AST_FULL_WRITE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (full && load) |=> $stable(word)); // R3
  AST_TAKE_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (full && take) |=> (!full && sent_ev)); // R4
endmodule

// File: rtl/hcomm_rxbuf.sv
module hcomm_rxbuf #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arrive,
  input  logic [DW-1:0] arrive_word,
  input  logic          host_rd,
  input  logic          clr_arrv,
  output logic          full,
  output logic [DW-1:0] word,
  output logic          arrv_ev
);
  logic accept;
  assign accept = arrive && !full;

  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      word <= '0;
    end else if (accept) begin
      full <= 1'b1;
      word <= arrive_word;
    end else if (host_rd) begin
      full <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           arrv_ev <= 1'b0;
    else if (accept)   arrv_ev <= 1'b1;
    else if (clr_arrv) arrv_ev <= 1'b0;
  end

  AST_FULL_KEEPS_WORD: assert property (@(posedge clk) disable iff (rst)
    (full && !host_rd) |=> (full && $stable(word))); // R5
  AST_READ_EMPTIES: assert property (@(posedge clk) disable iff (rst)
    (full && host_rd) |=> !full); // R6
endmodule

// File: rtl/hcomm_irq.sv
module hcomm_irq
  import hcomm_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 ic_wr,
  input  logic [NUM_CAUSE-1:0] ic_en_in,
  input  logic                 clr_proc,
  input  logic                 mod_req,
  input  logic [NUM_CAUSE-1:0] causes_raw,
  output logic [NUM_CAUSE-1:0] enables,
  output logic                 proc_sticky,
  output logic                 host_irq
);
  logic [NUM_CAUSE-1:0] causes;

  always_ff @(posedge clk) begin
    if (rst)        enables <= '0;
    else if (ic_wr) enables <= ic_en_in;
  end

  always_ff @(posedge clk) begin
    if (rst)                   proc_sticky <= 1'b0;
    else if (mod_req)          proc_sticky <= 1'b1;
    else if (ic_wr && clr_proc) proc_sticky <= 1'b0;
  end

  // the top cause position is the latched module request
  always_comb begin
    causes = causes_raw;
    causes[NUM_CAUSE-1] = proc_sticky;
  end

  always_ff @(posedge clk) begin
    if (rst) host_irq <= 1'b0;
    else     host_irq <= |(causes & enables);
  end

  AST_PROC_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (proc_sticky && !(ic_wr && clr_proc)) |=> proc_sticky); // R8
  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (rst)
    (enables == '0 && !ic_wr) |=> !host_irq); // R10
endmodule

// File: rtl/hcomm_regs.sv
module hcomm_regs
  import hcomm_pkg::*;
#(
  parameter int DW = 32,
  parameter int AW = 8,
  parameter int FLAG_PINS = 3
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 bus_wr,
  input  logic                 bus_rd,
  input  logic [AW-1:0]        bus_addr,
  input  logic [DW-1:0]        bus_wdata,
  output logic [DW-1:0]        bus_rdata,
  output logic                 tx_valid,
  output logic [DW-1:0]        tx_data,
  input  logic                 tx_take,
  input  logic                 rx_arrive,
  input  logic [DW-1:0]        rx_data,
  output logic                 rx_ready,
  input  logic                 mod_irq_req,
  input  logic                 tbc_irq,
  output logic                 site_rst_pull,
  output logic [FLAG_PINS-1:0] flag_pull,
  output logic                 nmi_pull,
  output logic                 host_irq
);
  localparam int CT_NMI = CT_FLAG_LO + FLAG_PINS;

  logic sel_data, sel_ctrl, sel_intc;
  assign sel_data = (bus_addr == AW'(OFS_DATA));
  assign sel_ctrl = (bus_addr == AW'(OFS_CTRL));
  assign sel_intc = (bus_addr == AW'(OFS_INTC));

  logic ic_wr;
  assign ic_wr = bus_wr && sel_intc;

  logic          tx_full, sent_ev, rx_full, arrv_ev, proc_sticky;
  logic [DW-1:0] rx_word;
  logic [NUM_CAUSE-1:0] enables;

  hcomm_txbuf #(.DW(DW)) u_tx (
    .clk(clk), .rst(rst),
    .load(bus_wr && sel_data), .load_word(bus_wdata),
    .take(tx_take), .clr_sent(ic_wr && bus_wdata[IC_CLR_SENT]),
    .full(tx_full), .word(tx_data), .sent_ev(sent_ev)
  );

  hcomm_rxbuf #(.DW(DW)) u_rx (
    .clk(clk), .rst(rst),
    .arrive(rx_arrive), .arrive_word(rx_data),
    .host_rd(bus_rd && sel_data), .clr_arrv(ic_wr && bus_wdata[IC_CLR_ARRV]),
    .full(rx_full), .word(rx_word), .arrv_ev(arrv_ev)
  );

  hcomm_irq u_irq (
    .clk(clk), .rst(rst),
    .ic_wr(ic_wr), .ic_en_in(bus_wdata[NUM_CAUSE-1:0]),
    .clr_proc(bus_wdata[IC_CLR_PROC]), .mod_req(mod_irq_req),
    .causes_raw({1'b0, tbc_irq, arrv_ev, sent_ev}),
    .enables(enables), .proc_sticky(proc_sticky), .host_irq(host_irq)
  );

  assign tx_valid = tx_full;
  assign rx_ready = !rx_full;

  // control pins: registered straight from the write
  always_ff @(posedge clk) begin
    if (rst) begin
      site_rst_pull <= 1'b1;
      flag_pull     <= '0;
      nmi_pull      <= 1'b0;
    end else if (bus_wr && sel_ctrl) begin
      site_rst_pull <= bus_wdata[CT_RST];
      flag_pull     <= bus_wdata[CT_FLAG_LO +: FLAG_PINS];
      nmi_pull      <= bus_wdata[CT_NMI];
    end
  end

  logic [DW-1:0] status;
  always_comb begin
    status          = '0;
    status[ST_OBF]  = tx_full;
    status[ST_IBF]  = rx_full;
    status[ST_IRQ]  = host_irq;
    status[ST_SENT] = sent_ev;
    status[ST_ARRV] = arrv_ev;
    status[ST_TBC]  = tbc_irq;
    status[ST_PROC] = proc_sticky;
  end

  always_ff @(posedge clk) begin
    if (rst)                      bus_rdata <= '0;
    else if (bus_rd && sel_data)  bus_rdata <= rx_word;
    else if (bus_rd && sel_ctrl)  bus_rdata <= status;
    else if (bus_rd && sel_intc)  bus_rdata <= DW'(enables);
    else if (bus_rd)              bus_rdata <= '0;
  end

  AST_CTRL_NMI_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && sel_ctrl) |=> (nmi_pull == $past(bus_wdata[CT_NMI]))); // R11
  AST_RDATA_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && !sel_data && !sel_ctrl && !sel_intc) |=> (bus_rdata == '0)); // R1
endmodule

// File: tb/sim_hcomm_regs.sv
module sim_hcomm_regs;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, tx_data, rx_data = '0;
  logic        tx_valid, tx_take = 1'b0, rx_arrive = 1'b0, rx_ready;
  logic        mod_irq_req = 1'b0, tbc_irq = 1'b0;
  logic        site_rst_pull, nmi_pull, host_irq;
  logic [2:0]  flag_pull;

  always #4 clk = ~clk; // 125 MHz

  hcomm_regs u0 (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_take(tx_take), .rx_arrive(rx_arrive), .rx_data(rx_data),
    .rx_ready(rx_ready), .mod_irq_req(mod_irq_req), .tbc_irq(tbc_irq),
    .site_rst_pull(site_rst_pull), .flag_pull(flag_pull), .nmi_pull(nmi_pull),
    .host_irq(host_irq)
  );

  int checks = 0, failures = 0;
  bit finished = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic        rd_fire = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops one expectation per accepted read
  always @(posedge clk) rd_fire <= bus_rd;
  initial forever begin
    @(negedge clk);
    if (rd_fire) begin
      if (exp_q.size() == 0) chk("R1 unexpected read", 32'h1, 32'h0);
      else chk(tag_q.pop_front(), bus_rdata, exp_q.pop_front());
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R12 site reset held in reset", {31'b0, site_rst_pull}, 32'h1);
    rst = 1'b0;
    settle();
    chk("R12 pins after reset", {27'b0, host_irq, nmi_pull, flag_pull}, 32'h0);
    chk("R12 site reset still held", {31'b0, site_rst_pull}, 32'h1);
    chk("R12 link idle", {30'b0, tx_valid, rx_ready}, 32'h1);
    rd(8'h14, 32'h0, "R12 status after reset");
    rd(8'h1C, 32'h0, "R1 unmapped reads zero");

    // outgoing path
    wr(8'h10, 32'hA5A5_0001);
    settle();
    chk("R2 tx_valid", {31'b0, tx_valid}, 32'h1);
    chk("R2 tx_data", tx_data, 32'hA5A5_0001);
    rd(8'h14, 32'h01, "R2 status full flag");
    wr(8'h10, 32'h0000_1234);
    settle();
    chk("R3 write while full ignored", tx_data, 32'hA5A5_0001);
    @(negedge clk); tx_take = 1'b1;
    @(negedge clk); tx_take = 1'b0;
    settle();
    chk("R4 tx_valid drops", {31'b0, tx_valid}, 32'h0);
    chk("R10 masked cause quiet", {31'b0, host_irq}, 32'h0);
    rd(8'h14, 32'h10, "R4 sent event latched");
    wr(8'h18, 32'h1);
    settle();
    chk("R10 sent cause enabled", {31'b0, host_irq}, 32'h1);
    rd(8'h14, 32'h18, "R10 status irq bit");
    rd(8'h18, 32'h1, "R7 enables read back");
    wr(8'h18, 32'h11);
    settle();
    rd(8'h14, 32'h00, "R7 sent event cleared");
    chk("R7 irq drops after clear", {31'b0, host_irq}, 32'h0);

    // incoming path
    @(negedge clk); rx_arrive = 1'b1; rx_data = 32'hDEAD_BEEF;
    @(negedge clk); rx_arrive = 1'b0;
    settle();
    chk("R5 rx_ready drops", {31'b0, rx_ready}, 32'h0);
    rd(8'h14, 32'h22, "R5 status full and event");
    wr(8'h18, 32'h2);
    settle();
    chk("R10 arrival cause enabled", {31'b0, host_irq}, 32'h1);
    @(negedge clk); rx_arrive = 1'b1; rx_data = 32'h0000_1111;
    @(negedge clk); rx_arrive = 1'b0;
    rd(8'h10, 32'hDEAD_BEEF, "R5 arrival while full ignored / R6 read word");
    settle();
    chk("R6 rx_ready after read", {31'b0, rx_ready}, 32'h1);
    rd(8'h14, 32'h28, "R6 full flag cleared by read");
    wr(8'h18, 32'h20);
    settle();
    rd(8'h14, 32'h00, "R7 arrival event cleared");

    // test controller level
    wr(8'h18, 32'h4);
    @(negedge clk); tbc_irq = 1'b1;
    settle();
    chk("R9 tbc raises irq", {31'b0, host_irq}, 32'h1);
    rd(8'h14, 32'h48, "R9 tbc status follows level");
    @(negedge clk); tbc_irq = 1'b0;
    settle();
    rd(8'h14, 32'h00, "R9 tbc status drops with level");

    // module request
    wr(8'h18, 32'h0);
    @(negedge clk); mod_irq_req = 1'b1;
    @(negedge clk); mod_irq_req = 1'b0;
    settle();
    rd(8'h14, 32'h80, "R8 module request latched");
    chk("R10 module cause masked", {31'b0, host_irq}, 32'h0);
    wr(8'h18, 32'h8);
    settle();
    chk("R10 module cause enabled", {31'b0, host_irq}, 32'h1);
    wr(8'h18, 32'h40);
    settle();
    rd(8'h14, 32'h00, "R8 module request cleared");

    // control pins
    wr(8'h14, 32'h1E);
    settle();
    chk("R11 pins 1Eh", {27'b0, site_rst_pull, nmi_pull, flag_pull}, 32'h0F);
    wr(8'h14, 32'h03);
    settle();
    chk("R11 pins 03h", {27'b0, site_rst_pull, nmi_pull, flag_pull}, 32'h11);
    wr(8'h14, 32'h00);
    settle();
    chk("R11 pins 00h", {27'b0, site_rst_pull, nmi_pull, flag_pull}, 32'h00);

    settle();
    chk("R1 all reads answered", exp_q.size(), 32'h0);
    summary();
  end
endmodule